// File: doc/BRIEF.md
# Token-Gated Transmit Handshake Sequencer

This block is the transmit control sequencer of a node on a token-passing network. The node holds at most one outbound packet. The host writes a destination identifier and issues a transmit command. Each time the node receives the token, the sequencer decides what to do. With nothing pending, it hands the token on at once. With a request pending, it first sends a free-buffer enquiry to the destination and waits for a reply.

If the reply is a positive acknowledge, the sequencer strobes the packet frame and then the CRC frame to an external serializer. It then waits for a delivery acknowledge. A negative acknowledge, or no reply before the timeout, ends the enquiry without sending data. In that case the request stays pending for the next token. After the CRC, an acknowledge marks the delivery as good and silence marks it as failed.

Three sticky status bits record the outcome, and a per-bit mask selects which of them drive the host interrupt. All response waits use a single cycle-count timeout. That timeout is a base count scaled by a power of two chosen from the line rate.

Top module: `tx_handshake_seq`

## Requirements
- R1: After reset no strobe is active, `stat` equals 3'b001 and `irq` is low. In `stat`, bit 0 means the transmitter is available, bit 1 means the delivery was acknowledged and bit 2 means the transmission failed.
- R2: A `host_cmd_wr` pulse while the sequencer is idle does three things: it stores `host_dest_id`, marks a request pending and clears all of `stat`. The same pulse during an attempt is ignored.
- R3: A `token_rx` pulse with nothing pending yields `pass_token` for exactly one cycle, on the cycle after the pulse, and no frame strobe.
- R4: A `token_rx` pulse with a request pending yields a one-cycle `send_enq` on the cycle after the pulse, with `frame_dest` equal to the stored destination.
- R5: An acknowledge during the enquiry wait yields `send_data` on the next cycle. The `ser_done` that ends the data frame yields `send_crc` on the next cycle.
- R6: A negative acknowledge during the enquiry wait yields `pass_token` on the next cycle with no data strobe. `stat` is left unchanged and the request stays pending.
- R7: A response wait expires after L = BASE_CNT << min(`rate_sel`, 6) cycles without a response. An expired enquiry wait passes the token, leaves `stat` unchanged and keeps the request pending.
- R8: An acknowledge during the wait after the CRC sets `stat` bits 1 and 0, passes the token on the next cycle and clears the pending request.
- R9: Silence during the wait after the CRC leads, once L cycles have passed, to `stat` bits 2 and 0 being set, the token being passed and the request being cleared.
- R10: `irq` equals the OR of (`stat` AND `irq_mask`).
- R11: Each token hold passes the token exactly once. A `token_rx` pulse that arrives during an attempt is ignored.

Top module parameters: ID_W (destination width, 8) and BASE_CNT (timeout base in cycles, 205).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd_wr | input | 1 | Transmit command pulse from the host |
| host_dest_id | input | ID_W | Destination identifier loaded with the command |
| irq_mask | input | 3 | Per-bit interrupt enable for `stat` |
| rate_sel | input | 3 | Timeout scale select (values above 6 act as 6) |
| token_rx | input | 1 | Pulse: the node has just received the token |
| resp_ack | input | 1 | Pulse: decoded acknowledge from the destination |
| resp_nak | input | 1 | Pulse: decoded negative acknowledge |
| ser_done | input | 1 | Pulse: serializer has finished the current frame |
| send_enq | output | 1 | Strobe: start the free-buffer enquiry frame |
| send_data | output | 1 | Strobe: start the packet frame |
| send_crc | output | 1 | Strobe: start the CRC frame |
| frame_dest | output | ID_W | Destination of the frames being sent |
| pass_token | output | 1 | Strobe: hand the token to the next node |
| stat | output | 3 | Status bits: {failed, delivered, available} |
| irq | output | 1 | Host interrupt |

## Verification
The bench exercises the four ways an attempt can end: a good delivery, a delivery that meets silence, a negative answer and an enquiry timeout. It times every timeout against L for each scale select, including the select values that saturate. A timer that is off by one, or that scales the wrong way, moves the token pass away from cycle L. It repeats a token after a negative answer or a timeout to show that the request survived. A design that drops the request would pass the token with no enquiry at that point. It also sends a stray command and a stray token in the middle of an attempt. A design that accepts them would change `frame_dest` or pass the token a second time.

// File: rtl/txh_pkg.sv
package txh_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ENQ, S_ENQ_BUSY, S_ENQ_WAIT,
    S_DATA, S_DATA_BUSY, S_CRC, S_CRC_BUSY,
    S_ACK_WAIT, S_PASS
  } seq_state_t;

  localparam int STAT_W   = 3;
  localparam int ST_AVAIL = 0;
  localparam int ST_DELIV = 1;
  localparam int ST_FAIL  = 2;
  localparam int MAX_SEL  = 6;

  // Response wait length: base count times 2^min(sel, MAX_SEL)
  function automatic int unsigned scaled_limit(int unsigned base, logic [2:0] sel);
    logic [2:0] s;
    s = (sel > 3'(MAX_SEL)) ? 3'(MAX_SEL) : sel;
    return base << s;
  endfunction

endpackage

// File: rtl/txh_resp_timer.sv
module txh_resp_timer
  import txh_pkg::*;
#(
  parameter int unsigned BASE_CNT = 205
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [2:0] rate_sel,
  output logic       expire
);
  localparam int TMR_W = $clog2(BASE_CNT + 1) + MAX_SEL;

  logic [TMR_W-1:0] limit;
  logic [TMR_W-1:0] cnt;

  assign limit = TMR_W'(scaled_limit(BASE_CNT, rate_sel));

  // Preload while disarmed, count down while a wait is open
  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!arm)           cnt <= limit;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expire = arm && (cnt == TMR_W'(1));

  // R7
  arm_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> cnt != '0);

endmodule

// File: rtl/txh_fsm.sv
module txh_fsm
  import txh_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_cmd_wr,
  input  logic [ID_W-1:0] host_dest_id,
  input  logic            token_rx,
  input  logic            resp_ack,
  input  logic            resp_nak,
  input  logic            ser_done,
  input  logic            tmr_expire,
  output logic            tmr_arm,
  output logic            cmd_accept,
  output logic            ev_deliv,
  output logic            ev_fail,
  output logic            send_enq,
  output logic            send_data,
  output logic            send_crc,
  output logic            pass_token,
  output logic [ID_W-1:0] frame_dest
);
  seq_state_t st, st_n;
  logic       pending;
  logic [ID_W-1:0] dest_q;

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:      if (token_rx) st_n = pending ? S_ENQ : S_PASS;
      S_ENQ:       st_n = S_ENQ_BUSY;
      S_ENQ_BUSY:  if (ser_done) st_n = S_ENQ_WAIT;
      S_ENQ_WAIT: begin
        if (resp_ack)                    st_n = S_DATA;
        else if (resp_nak || tmr_expire) st_n = S_PASS;
      end
      S_DATA:      st_n = S_DATA_BUSY;
      S_DATA_BUSY: if (ser_done) st_n = S_CRC;
      S_CRC:       st_n = S_CRC_BUSY;
      S_CRC_BUSY:  if (ser_done) st_n = S_ACK_WAIT;
      S_ACK_WAIT:  if (resp_ack || tmr_expire) st_n = S_PASS;
      S_PASS:      st_n = S_IDLE;
      default:     st_n = S_IDLE;
    endcase
  end

  assign cmd_accept = host_cmd_wr && (st == S_IDLE);
  assign ev_deliv   = (st == S_ACK_WAIT) && resp_ack;
  assign ev_fail    = (st == S_ACK_WAIT) && !resp_ack && tmr_expire;
  assign tmr_arm    = (st == S_ENQ_WAIT) || (st == S_ACK_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pending <= 1'b0;
      dest_q  <= '0;
    end else begin
      st <= st_n;
      if (cmd_accept) begin
        pending <= 1'b1;
        dest_q  <= host_dest_id;
      end else if (ev_deliv || ev_fail) begin
        pending <= 1'b0;
      end
    end
  end

  assign send_enq   = (st == S_ENQ);
  assign send_data  = (st == S_DATA);
  assign send_crc   = (st == S_CRC);
  assign pass_token = (st == S_PASS);
  assign frame_dest = dest_q;

  // R5
  data_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_data |-> ($past(st) == S_ENQ_WAIT) && $past(resp_ack));

  // R5
  crc_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_crc |-> ($past(st) == S_DATA_BUSY) && $past(ser_done));

  // R6
  nak_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENQ_WAIT && resp_nak && !resp_ack) |=> pass_token);

  // R2
  cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cmd_wr && st != S_IDLE) |=> $stable(frame_dest));

  // R11
  single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_token |=> !pass_token);

endmodule

// File: rtl/txh_status.sv
module txh_status
  import txh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_accept,
  input  logic              ev_deliv,
  input  logic              ev_fail,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic [STAT_W-1:0] set_vec;

  always_comb begin
    set_vec           = '0;
    set_vec[ST_AVAIL] = ev_deliv || ev_fail;
    set_vec[ST_DELIV] = ev_deliv;
    set_vec[ST_FAIL]  = ev_fail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          stat <= STAT_W'(1) << ST_AVAIL;
    else if (cmd_accept) stat <= '0;
    else                 stat <= stat | set_vec;
  end

  assign irq = |(stat & irq_mask);

  // R8
  deliv_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deliv |=> stat[ST_DELIV] && stat[ST_AVAIL]);

  // R9
  fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> stat[ST_FAIL] && stat[ST_AVAIL]);

  // R2
  cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> stat == '0);

endmodule

// File: rtl/tx_handshake_seq.sv
module tx_handshake_seq
  import txh_pkg::*;
#(
  parameter int          ID_W     = 8,
  parameter int unsigned BASE_CNT = 205
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cmd_wr,
  input  logic [ID_W-1:0]   host_dest_id,
  input  logic [STAT_W-1:0] irq_mask,
  input  logic [2:0]        rate_sel,
  input  logic              token_rx,
  input  logic              resp_ack,
  input  logic              resp_nak,
  input  logic              ser_done,
  output logic              send_enq,
  output logic              send_data,
  output logic              send_crc,
  output logic [ID_W-1:0]   frame_dest,
  output logic              pass_token,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic tmr_arm, tmr_expire, cmd_accept, ev_deliv, ev_fail;

  txh_fsm #(.ID_W(ID_W)) fsm_i (
    .clk, .rst_n, .host_cmd_wr, .host_dest_id, .token_rx,
    .resp_ack, .resp_nak, .ser_done, .tmr_expire,
    .tmr_arm, .cmd_accept, .ev_deliv, .ev_fail,
    .send_enq, .send_data, .send_crc, .pass_token, .frame_dest
  );

  txh_resp_timer #(.BASE_CNT(BASE_CNT)) tmr_i (
    .clk, .rst_n, .arm(tmr_arm), .rate_sel, .expire(tmr_expire)
  );

  txh_status stat_i (
    .clk, .rst_n, .cmd_accept, .ev_deliv, .ev_fail, .irq_mask, .stat, .irq
  );

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_deliv, ev_fail}));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat & irq_mask) != '0);

endmodule

// File: tb/tx_handshake_seq_tb.sv
`timescale 1ns/1ps
module tx_handshake_seq_tb_top;
  localparam int ID_W = 8;
  localparam int BASE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_cmd_wr = 1'b0;
  logic [ID_W-1:0] host_dest_id = '0;
  logic [2:0] irq_mask = '0;
  logic [2:0] rate_sel = '0;
  logic token_rx = 1'b0, resp_ack = 1'b0, resp_nak = 1'b0, ser_done = 1'b0;
  logic send_enq, send_data, send_crc, pass_token, irq;
  logic [ID_W-1:0] frame_dest;
  logic [2:0] stat;

  int total = 0;
  int bad = 0;
  bit m_pend = 1'b0;
  logic [ID_W-1:0] m_dest = '0;
  logic [2:0] m_stat = 3'b001;

  always #2.5 clk = ~clk;

  tx_handshake_seq #(.ID_W(ID_W), .BASE_CNT(BASE)) dut_i (
    .clk, .rst_n, .host_cmd_wr, .host_dest_id, .irq_mask, .rate_sel,
    .token_rx, .resp_ack, .resp_nak, .ser_done,
    .send_enq, .send_data, .send_crc, .frame_dest, .pass_token, .stat, .irq
  );

  function automatic int exp_limit(int sel);
    int f = 1;
    int s = (sel > 6) ? 6 : sel;
    for (int i = 0; i < s; i++) f = f * 2;
    return BASE * f;
  endfunction

  function automatic int strobes();
    return {28'd0, send_enq, send_data, send_crc, pass_token};
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic host_cmd(logic [ID_W-1:0] d);
    host_cmd_wr = 1'b1; host_dest_id = d;
    step();
    host_cmd_wr = 1'b0;
    m_pend = 1'b1; m_dest = d; m_stat = 3'b000;
    check_eq("R2", "stat cleared by command", stat, 0);
  endtask

  task automatic pulse_ser_done();
    ser_done = 1'b1; step(); ser_done = 1'b0;
  endtask

  task automatic wait_pass(output int n);
    n = 0;
    while (!pass_token && n < 1000) begin step(); n++; end
  endtask

  // kind: 0 ack/ack, 1 ack/silence, 2 nak, 3 enquiry timeout
  task automatic attempt(int kind, bit inject);
    int lim = exp_limit(int'(rate_sel));
    int n;
    token_rx = 1'b1; step(); token_rx = 1'b0;
    if (!m_pend) begin
      check_eq("R3", "strobes on empty token", strobes(), 4'b0001);
      step();
      check_eq("R11", "strobes after pass", strobes(), 0);
      return;
    end
    check_eq("R4", "enquiry strobe", strobes(), 4'b1000);
    check_eq("R4", "frame_dest", frame_dest, m_dest);
    step();
    if (inject) begin
      host_cmd_wr = 1'b1; host_dest_id = ~m_dest; token_rx = 1'b1;
      step();
      host_cmd_wr = 1'b0; token_rx = 1'b0;
      check_eq("R11", "stray token/cmd ignored", strobes(), 0);
      check_eq("R2", "dest kept during attempt", frame_dest, m_dest);
    end
    repeat ($urandom % 3) step();
    pulse_ser_done();
    if (kind == 3) begin
      wait_pass(n);
      check_eq("R7", "enquiry timeout length", n, lim);
      check_eq("R7", "stat after timeout", stat, m_stat);
      step();
      return;
    end
    repeat ($urandom % lim) step();
    if (kind == 2) begin
      resp_nak = 1'b1; step(); resp_nak = 1'b0;
      check_eq("R6", "nak passes token", strobes(), 4'b0001);
      check_eq("R6", "stat after nak", stat, m_stat);
      step();
      return;
    end
    resp_ack = 1'b1; step(); resp_ack = 1'b0;
    check_eq("R5", "data strobe after ack", strobes(), 4'b0100);
    step();
    repeat ($urandom % 4) step();
    pulse_ser_done();
    check_eq("R5", "crc strobe after data", strobes(), 4'b0010);
    step();
    pulse_ser_done();
    if (kind == 0) begin
      repeat ($urandom % lim) step();
      resp_ack = 1'b1; step(); resp_ack = 1'b0;
      check_eq("R8", "pass after delivery ack", strobes(), 4'b0001);
      m_stat = 3'b011; m_pend = 1'b0;
      check_eq("R8", "stat after delivery", stat, m_stat);
    end else begin
      wait_pass(n);
      check_eq("R9", "silence timeout length", n, lim);
      m_stat = 3'b101; m_pend = 1'b0;
      check_eq("R9", "stat after silence", stat, m_stat);
    end
    step();
    check_eq("R11", "single pass", strobes(), 0);
  endtask

  task automatic check_irq();
    #1;
    check_eq("R10", "irq", irq, |(m_stat & irq_mask));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check_eq("R1", "reset strobes", strobes(), 0);
    check_eq("R1", "reset stat", stat, 3'b001);
    check_eq("R1", "reset irq", irq, 0);
    irq_mask = 3'b001; check_irq();

    attempt(0, 1'b0);                       // R3 nothing pending
    host_cmd(8'h5A); irq_mask = 3'b111; check_irq();
    rate_sel = 3'd0; attempt(0, 1'b0);      // R8
    check_irq();
    attempt(0, 1'b0);                       // request cleared: plain pass
    host_cmd(8'hC3);
    attempt(2, 1'b1);                       // R6 with stray inputs
    attempt(3, 1'b0);                       // R7 request still pending
    rate_sel = 3'd7; attempt(3, 1'b0);      // saturating select
    rate_sel = 3'd1; attempt(1, 1'b0);      // R9
    irq_mask = 3'b100; check_irq();
    irq_mask = 3'b010; check_irq();

    for (int it = 0; it < 30; it++) begin
      if (!m_pend && ($urandom % 4) != 0) host_cmd(ID_W'($urandom));
      rate_sel = 3'($urandom);
      irq_mask = 3'($urandom);
      attempt(int'($urandom % 4), 1'($urandom));
      check_irq();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule